// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank

This block holds the pin state for four GPIO ports behind a small 32-bit register bus. A host writes byte addresses with a write strobe, and read data comes back from the same address in the same cycle. Output levels, directions and one per-pin selection field are never rewritten whole. Each has a pair of registers: a one-to-set register and a one-to-clear register. Because of this, several agents can change separate bits without a read-modify-write sequence.

Ports A, B and C are plain bidirectional ports of 8, 24 and 13 pins. Port D is irregular. It mixes six bidirectional pins, up to 28 input-only pins and 24 output-only pins in one register set:
- The direction bits of its six bidirectional pins are held in the upper half of the port C direction register.
- Its bidirectional input bits are placed out of line in the input word.

Pads are modelled as separate input, output-level and output-enable vectors.

Top module: `gpio_bank`

## Requirements
- R1: After reset every output level, direction bit and selection bit is 0, so every pad output and output enable is low and every state register reads 0.
- R2: Writing a set register ORs the written ones into the addressed register on the next clock edge. Zero bits in the write leave the register unchanged.
- R3: Writing a clear register clears the bits written as one on the next clock edge. Zero bits in the write leave the register unchanged.
- R4: A direction bit of 1 drives the matching pad output enable high. The pad output level always equals the stored output bit.
- R5: Port A uses these word addresses: 0x040 input, 0x044 output set, 0x048 output clear, 0x04C output state, 0x050 direction set, 0x054 direction clear, 0x058 direction state. Port B uses the same layout offset by 0x020, so 0x060 to 0x078.
- R6: Port C uses these addresses: 0x010, 0x014 and 0x018 for direction set, clear and state; 0x01C for input; 0x020 and 0x024 for output set and clear; 0x028, 0x02C and 0x030 for selection set, clear and state. The selection state drives the `c_sel` output.
- R7: Port D bidirectional pin n takes its output level from bit 25+n of the port D output register. It takes its direction from bit 25+n of the port C direction register, and reading 0x018 shows that bit.
- R8: The port D input word at 0x000 has the following layout:
  - Bits 10 to 14 carry bidirectional pins 0 to 4, and bit 24 carries bidirectional pin 5.
  - Every other bit n below 28 carries input-only pin n.
  - Bits 28 to 31 read 0.
- R9: Output-only pin n follows bit n (0 to 23) of the port D output register, set at 0x004, cleared at 0x008 and read at 0x00C. Bits 24 and 31 of that register cannot be set and read 0.
- R10: Reads of any set or clear address, and of any unmapped address, return 0. Writes to input or state addresses change nothing.
- R11: With the write strobe low, no register changes, whatever the address and data.
- R12: Written bits above a port's pin count are ignored, and they read 0 from that port's state registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| a_pad_in | input | 8 | Port A pad inputs |
| a_pad_out | output | 8 | Port A output levels |
| a_pad_oe | output | 8 | Port A output enables |
| b_pad_in | input | 24 | Port B pad inputs |
| b_pad_out | output | 24 | Port B output levels |
| b_pad_oe | output | 24 | Port B output enables |
| c_pad_in | input | 13 | Port C pad inputs |
| c_pad_out | output | 13 | Port C output levels |
| c_pad_oe | output | 13 | Port C output enables |
| c_sel | output | 13 | Port C selection state |
| d_io_in | input | 6 | Port D bidirectional pad inputs |
| d_io_out | output | 6 | Port D bidirectional output levels |
| d_io_oe | output | 6 | Port D bidirectional output enables |
| d_gpi | input | 28 | Port D input-only pins |
| d_gpo | output | 24 | Port D output-only pins |

## Verification
The bench builds the block with its default widths: 8, 24 and 13 pins for ports A to C, and 6, 28 and 24 pins for port D. These are also the largest values the placement rules allow. At these widths the out-of-line input positions at bits 10 to 14 and 24 sit inside the input-only range. This lets the bench show that a bidirectional pin overrides the input-only pin at the same position. The widths also make the unwritable holes at bits 24 and 31 of the port D output word, and the shared port C direction word, visible at the bus.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Word addresses; address decode and neighbouring software depend on them.
  localparam int OFF_D_IN    = 'h000;
  localparam int OFF_D_SET   = 'h004;
  localparam int OFF_D_CLR   = 'h008;
  localparam int OFF_D_OUT   = 'h00C;
  localparam int OFF_C_DSET  = 'h010;
  localparam int OFF_C_DCLR  = 'h014;
  localparam int OFF_C_DIR   = 'h018;
  localparam int OFF_C_IN    = 'h01C;
  localparam int OFF_C_SET   = 'h020;
  localparam int OFF_C_CLR   = 'h024;
  localparam int OFF_C_SSET  = 'h028;
  localparam int OFF_C_SCLR  = 'h02C;
  localparam int OFF_C_SEL   = 'h030;
  localparam int OFF_A_BASE  = 'h040;
  localparam int OFF_B_BASE  = 'h060;
  // Offsets inside a plain port window.
  localparam int REL_IN   = 'h00;
  localparam int REL_SET  = 'h04;
  localparam int REL_CLR  = 'h08;
  localparam int REL_OUT  = 'h0C;
  localparam int REL_DSET = 'h10;
  localparam int REL_DCLR = 'h14;
  localparam int REL_DIR  = 'h18;

  // Port D bit placement.
  localparam int D_IO_SHIFT   = 25;
  localparam int D_IO_IN_LO   = 10;
  localparam int D_IO_IN_LAST = 24;

  // Next value of a set/clear register pair for one bus write.
  function automatic logic [31:0] setclr_next(input logic [31:0] q,
                                              input logic set_en,
                                              input logic clr_en,
                                              input logic [31:0] bits);
    if (set_en)      return q | bits;
    else if (clr_en) return q & ~bits;
    else             return q;
  endfunction

  // Mask of the first n bits.
  function automatic logic [31:0] low_mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int          W    = 32,
  parameter logic [31:0] MASK = 32'hFFFF_FFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [31:0]  wdata,
  output logic [W-1:0] q
);
  import gpio_bank_pkg::*;
  localparam logic [31:0] LIVE = MASK & low_mask(W);

  logic [31:0] cur, nxt;
  assign cur = 32'(q);
  assign nxt = setclr_next(cur, set_en, clr_en, wdata & LIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt[W-1:0];
  end
endmodule

// File: rtl/gpio_dport_pack.sv
module gpio_dport_pack #(
  parameter int IO_W  = 6,
  parameter int GPI_W = 28
) (
  input  logic [IO_W-1:0]  io_in,
  input  logic [GPI_W-1:0] gpi,
  output logic [31:0]      word
);
  import gpio_bank_pkg::*;
  localparam int IO_LO_LAST = D_IO_IN_LO + IO_W - 2;

  for (genvar i = 0; i < 32; i++) begin : g_bit
    if (i >= D_IO_IN_LO && i <= IO_LO_LAST) begin : g_io
      assign word[i] = io_in[i - D_IO_IN_LO];
    end else if (i == D_IO_IN_LAST) begin : g_last
      assign word[i] = io_in[IO_W-1];
    end else if (i < GPI_W) begin : g_gpi
      assign word[i] = gpi[i];
    end else begin : g_zero
      assign word[i] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_bank_rdmux.sv
module gpio_bank_rdmux #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0] a_in, a_out, a_dir,
  input  logic [31:0] b_in, b_out, b_dir,
  input  logic [31:0] c_in, c_dir, c_sel,
  input  logic [31:0] d_in, d_out,
  output logic [31:0] rdata
);
  import gpio_bank_pkg::*;
  always_comb begin
    rdata = 32'h0;
    case (addr)
      ADDR_W'(OFF_D_IN):              rdata = d_in;
      ADDR_W'(OFF_D_OUT):             rdata = d_out;
      ADDR_W'(OFF_C_DIR):             rdata = c_dir;
      ADDR_W'(OFF_C_IN):              rdata = c_in;
      ADDR_W'(OFF_C_SEL):             rdata = c_sel;
      ADDR_W'(OFF_A_BASE + REL_IN):   rdata = a_in;
      ADDR_W'(OFF_A_BASE + REL_OUT):  rdata = a_out;
      ADDR_W'(OFF_A_BASE + REL_DIR):  rdata = a_dir;
      ADDR_W'(OFF_B_BASE + REL_IN):   rdata = b_in;
      ADDR_W'(OFF_B_BASE + REL_OUT):  rdata = b_out;
      ADDR_W'(OFF_B_BASE + REL_DIR):  rdata = b_dir;
      default:                        rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int ADDR_W = 8,
  parameter int A_W    = 8,
  parameter int B_W    = 24,
  parameter int C_W    = 13,
  parameter int D_IO_W = 6,
  parameter int D_GI_W = 28,
  parameter int D_GO_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [A_W-1:0]    a_pad_in,
  output logic [A_W-1:0]    a_pad_out,
  output logic [A_W-1:0]    a_pad_oe,
  input  logic [B_W-1:0]    b_pad_in,
  output logic [B_W-1:0]    b_pad_out,
  output logic [B_W-1:0]    b_pad_oe,
  input  logic [C_W-1:0]    c_pad_in,
  output logic [C_W-1:0]    c_pad_out,
  output logic [C_W-1:0]    c_pad_oe,
  output logic [C_W-1:0]    c_sel,
  input  logic [D_IO_W-1:0] d_io_in,
  output logic [D_IO_W-1:0] d_io_out,
  output logic [D_IO_W-1:0] d_io_oe,
  input  logic [D_GI_W-1:0] d_gpi,
  output logic [D_GO_W-1:0] d_gpo
);
  import gpio_bank_pkg::*;

  localparam logic [31:0] IO_FIELD = low_mask(D_IO_W) << D_IO_SHIFT;
  localparam logic [31:0] D_MASK   = low_mask(D_GO_W) | IO_FIELD;
  localparam logic [31:0] CDIR_MASK = low_mask(C_W) | IO_FIELD;

  // Named write events; the checker watches the port A pair.
  logic wr_a_set, wr_a_clr, wr_a_dset, wr_a_dclr;
  logic wr_b_set, wr_b_clr, wr_b_dset, wr_b_dclr;
  logic wr_c_set, wr_c_clr, wr_c_dset, wr_c_dclr, wr_c_sset, wr_c_sclr;
  logic wr_d_set, wr_d_clr;

  function automatic logic hit(input logic we, input logic [ADDR_W-1:0] a, input int off);
    return we && (a == ADDR_W'(off));
  endfunction

  assign wr_a_set  = hit(bus_we, bus_addr, OFF_A_BASE + REL_SET);
  assign wr_a_clr  = hit(bus_we, bus_addr, OFF_A_BASE + REL_CLR);
  assign wr_a_dset = hit(bus_we, bus_addr, OFF_A_BASE + REL_DSET);
  assign wr_a_dclr = hit(bus_we, bus_addr, OFF_A_BASE + REL_DCLR);
  assign wr_b_set  = hit(bus_we, bus_addr, OFF_B_BASE + REL_SET);
  assign wr_b_clr  = hit(bus_we, bus_addr, OFF_B_BASE + REL_CLR);
  assign wr_b_dset = hit(bus_we, bus_addr, OFF_B_BASE + REL_DSET);
  assign wr_b_dclr = hit(bus_we, bus_addr, OFF_B_BASE + REL_DCLR);
  assign wr_c_set  = hit(bus_we, bus_addr, OFF_C_SET);
  assign wr_c_clr  = hit(bus_we, bus_addr, OFF_C_CLR);
  assign wr_c_dset = hit(bus_we, bus_addr, OFF_C_DSET);
  assign wr_c_dclr = hit(bus_we, bus_addr, OFF_C_DCLR);
  assign wr_c_sset = hit(bus_we, bus_addr, OFF_C_SSET);
  assign wr_c_sclr = hit(bus_we, bus_addr, OFF_C_SCLR);
  assign wr_d_set  = hit(bus_we, bus_addr, OFF_D_SET);
  assign wr_d_clr  = hit(bus_we, bus_addr, OFF_D_CLR);

  logic [A_W-1:0] a_out_q, a_dir_q;
  logic [B_W-1:0] b_out_q, b_dir_q;
  logic [C_W-1:0] c_out_q, c_sel_q;
  logic [31:0]    c_dir_q, d_out_q, d_in_word;

  gpio_setclr_reg #(.W(A_W)) u_a_out (.clk, .rst_n, .set_en(wr_a_set),  .clr_en(wr_a_clr),  .wdata(bus_wdata), .q(a_out_q));
  gpio_setclr_reg #(.W(A_W)) u_a_dir (.clk, .rst_n, .set_en(wr_a_dset), .clr_en(wr_a_dclr), .wdata(bus_wdata), .q(a_dir_q));
  gpio_setclr_reg #(.W(B_W)) u_b_out (.clk, .rst_n, .set_en(wr_b_set),  .clr_en(wr_b_clr),  .wdata(bus_wdata), .q(b_out_q));
  gpio_setclr_reg #(.W(B_W)) u_b_dir (.clk, .rst_n, .set_en(wr_b_dset), .clr_en(wr_b_dclr), .wdata(bus_wdata), .q(b_dir_q));
  gpio_setclr_reg #(.W(C_W)) u_c_out (.clk, .rst_n, .set_en(wr_c_set),  .clr_en(wr_c_clr),  .wdata(bus_wdata), .q(c_out_q));
  gpio_setclr_reg #(.W(C_W)) u_c_sel (.clk, .rst_n, .set_en(wr_c_sset), .clr_en(wr_c_sclr), .wdata(bus_wdata), .q(c_sel_q));
  gpio_setclr_reg #(.W(32), .MASK(CDIR_MASK)) u_c_dir (.clk, .rst_n, .set_en(wr_c_dset), .clr_en(wr_c_dclr), .wdata(bus_wdata), .q(c_dir_q));
  gpio_setclr_reg #(.W(32), .MASK(D_MASK))    u_d_out (.clk, .rst_n, .set_en(wr_d_set),  .clr_en(wr_d_clr),  .wdata(bus_wdata), .q(d_out_q));

  gpio_dport_pack #(.IO_W(D_IO_W), .GPI_W(D_GI_W)) u_dpack (.io_in(d_io_in), .gpi(d_gpi), .word(d_in_word));

  gpio_bank_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .addr(bus_addr),
    .a_in(32'(a_pad_in)), .a_out(32'(a_out_q)), .a_dir(32'(a_dir_q)),
    .b_in(32'(b_pad_in)), .b_out(32'(b_out_q)), .b_dir(32'(b_dir_q)),
    .c_in(32'(c_pad_in)), .c_dir(c_dir_q), .c_sel(32'(c_sel_q)),
    .d_in(d_in_word), .d_out(d_out_q),
    .rdata(bus_rdata));

  assign a_pad_out = a_out_q;
  assign a_pad_oe  = a_dir_q;
  assign b_pad_out = b_out_q;
  assign b_pad_oe  = b_dir_q;
  assign c_pad_out = c_out_q;
  assign c_pad_oe  = c_dir_q[C_W-1:0];
  assign c_sel     = c_sel_q;
  assign d_io_out  = d_out_q[D_IO_SHIFT +: D_IO_W];
  assign d_io_oe   = c_dir_q[D_IO_SHIFT +: D_IO_W];
  assign d_gpo     = d_out_q[D_GO_W-1:0];
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int ADDR_W = 8,
  parameter int A_W    = 8,
  parameter int D_IO_W = 6,
  parameter int D_GO_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [A_W-1:0]    a_pad_out,
  input logic [A_W-1:0]    a_pad_oe,
  input logic [D_IO_W-1:0] d_io_out,
  input logic [D_IO_W-1:0] d_io_oe,
  input logic [D_GO_W-1:0] d_gpo,
  input logic              wr_a_set,
  input logic              wr_a_clr
);
  import gpio_bank_pkg::*;

  p_set_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a_set |=> ((a_pad_out & $past(bus_wdata[A_W-1:0])) == $past(bus_wdata[A_W-1:0])));

  p_set_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a_set |=> ((a_pad_out & $past(a_pad_out)) == $past(a_pad_out)));

  p_clr_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a_clr |=> ((a_pad_out & $past(bus_wdata[A_W-1:0])) == '0));

  p_clr_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a_clr |=> ((a_pad_out | $past(a_pad_out)) == $past(a_pad_out)));

  p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(a_pad_out) && $stable(a_pad_oe) && $stable(d_io_out)
                 && $stable(d_io_oe) && $stable(d_gpo)));

  p_setclr_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_D_SET) || bus_addr == ADDR_W'(OFF_C_DCLR)) |-> (bus_rdata == 32'h0));

  p_dout_holes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_D_OUT)) |-> (!bus_rdata[24] && !bus_rdata[31]));

  p_dir_shared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_C_DIR)) |-> (bus_rdata[D_IO_SHIFT +: D_IO_W] == d_io_oe));

  p_dout_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_D_OUT)) |-> (bus_rdata[D_IO_SHIFT +: D_IO_W] == d_io_out
                                          && bus_rdata[D_GO_W-1:0] == d_gpo));
endmodule

bind gpio_bank gpio_bank_chk #(.ADDR_W(ADDR_W), .A_W(A_W), .D_IO_W(D_IO_W), .D_GO_W(D_GO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .a_pad_out(a_pad_out), .a_pad_oe(a_pad_oe),
  .d_io_out(d_io_out), .d_io_oe(d_io_oe), .d_gpo(d_gpo),
  .wr_a_set(wr_a_set), .wr_a_clr(wr_a_clr));

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  a_pad_in = '0, a_pad_out, a_pad_oe;
  logic [23:0] b_pad_in = '0, b_pad_out, b_pad_oe;
  logic [12:0] c_pad_in = '0, c_pad_out, c_pad_oe, c_sel;
  logic [5:0]  d_io_in = '0, d_io_out, d_io_oe;
  logic [27:0] d_gpi = '0;
  logic [23:0] d_gpo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_bank uut (.*);

  // {write addr, write data, read addr, expected read}
  localparam int NV = 18;
  localparam logic [79:0] VEC [NV] = '{
    {8'h44, 32'h0000_00A5, 8'h4C, 32'h0000_00A5},  // R2 R5 port A set
    {8'h44, 32'h0000_0000, 8'h4C, 32'h0000_00A5},  // R2 zeros do nothing
    {8'h48, 32'h0000_0081, 8'h4C, 32'h0000_0024},  // R3 clear
    {8'h44, 32'hFFFF_FF00, 8'h4C, 32'h0000_0024},  // R12 bits above width
    {8'h50, 32'h0000_000F, 8'h58, 32'h0000_000F},  // R4 R5 direction set
    {8'h54, 32'h0000_0003, 8'h58, 32'h0000_000C},  // R3 direction clear
    {8'h64, 32'h00AB_CDEF, 8'h6C, 32'h00AB_CDEF},  // R5 port B set
    {8'h68, 32'h00A0_000F, 8'h6C, 32'h000B_CDE0},  // R3 port B clear
    {8'h70, 32'hFF80_0001, 8'h78, 32'h0080_0001},  // R12 port B direction
    {8'h20, 32'h0000_1FFF, 8'h20, 32'h0000_0000},  // R10 set address reads 0
    {8'h10, 32'h7E00_1FFF, 8'h18, 32'h7E00_1FFF},  // R6 R7 shared direction
    {8'h14, 32'h0200_0001, 8'h18, 32'h7C00_1FFE},  // R7 shared direction clear
    {8'h28, 32'h0000_1234, 8'h30, 32'h0000_1234},  // R6 selection set
    {8'h2C, 32'h0000_0204, 8'h30, 32'h0000_1030},  // R6 selection clear
    {8'h04, 32'hFFFF_FFFF, 8'h0C, 32'h7EFF_FFFF},  // R9 port D holes
    {8'h08, 32'h4200_0001, 8'h0C, 32'h3CFF_FFFE},  // R9 port D clear
    {8'h4C, 32'hFFFF_FFFF, 8'h4C, 32'h0000_0024},  // R10 state address write ignored
    {8'h7C, 32'hFFFF_FFFF, 8'h7C, 32'h0000_0000}   // R10 unmapped address
  };

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, $sformatf("read %h", a), bus_rdata, exp);
  endtask

  // Input word of port D computed from the placement rules of R8.
  function automatic logic [31:0] d_word(input logic [5:0] io, input logic [27:0] gi);
    logic [31:0] w = {4'h0, gi};
    for (int k = 0; k < 5; k++) w[10 + k] = io[k];
    w[24] = io[5];
    return w;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, before reset is released
    check("R1", "a_pad_out", 32'(a_pad_out), 0);
    check("R1", "d_io_oe",   32'(d_io_oe),   0);
    rst_n = 1'b1;
    @(negedge clk);
    read_check("R1", 8'h4C, 0);
    read_check("R1", 8'h18, 0);
    read_check("R1", 8'h0C, 0);
    check("R1", "outputs", 32'(|{b_pad_out, b_pad_oe, c_pad_out, c_pad_oe, c_sel, d_gpo, d_io_out}), 0);

    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i][79:72], VEC[i][71:40]);
      read_check($sformatf("vector %0d", i), VEC[i][39:32], VEC[i][31:0]);
    end

    // R4 R7 R9 pad views after the table
    check("R4", "a_pad_out", 32'(a_pad_out), 32'h24);
    check("R4", "a_pad_oe",  32'(a_pad_oe),  32'h0C);
    check("R4", "b_pad_oe",  32'(b_pad_oe),  32'h80_0001);
    check("R6", "c_pad_out", 32'(c_pad_out), 32'h1FFF);
    check("R6", "c_pad_oe",  32'(c_pad_oe),  32'h1FFE);
    check("R6", "c_sel",     32'(c_sel),     32'h1030);
    check("R7", "d_io_oe",   32'(d_io_oe),   32'h3E);
    check("R7", "d_io_out",  32'(d_io_out),  32'h1E);
    check("R9", "d_gpo",     32'(d_gpo),     32'hFF_FFFE);

    // R11 strobe low: nothing changes
    @(negedge clk);
    bus_addr = 8'h48; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b0;
    @(posedge clk); @(negedge clk);
    bus_addr = 8'h08;
    @(posedge clk); @(negedge clk);
    read_check("R11", 8'h4C, 32'h24);
    read_check("R11", 8'h0C, 32'h3CFF_FFFE);

    // R5 R6 input reads
    a_pad_in = 8'h5A; b_pad_in = 24'hC3C3C3; c_pad_in = 13'h1ABC;
    read_check("R5", 8'h40, 32'h5A);
    read_check("R5", 8'h60, 32'hC3_C3C3);
    read_check("R6", 8'h1C, 32'h1ABC);

    // R8 input packing of port D
    d_gpi = '1; d_io_in = '0;
    read_check("R8", 8'h00, 32'h0EFF_83FF);
    check("R8", "model", d_word(6'h00, 28'hFFF_FFFF), 32'h0EFF_83FF);
    d_gpi = '0; d_io_in = 6'h3F;
    read_check("R8", 8'h00, 32'h0100_7C00);
    d_io_in = 6'b000001;
    read_check("R8", 8'h00, 32'h0000_0400);
    d_io_in = 6'b100000;
    read_check("R8", 8'h00, 32'h0100_0000);
    d_gpi = 28'hA5A_5A5A; d_io_in = 6'b010110;
    read_check("R8", 8'h00, d_word(6'b010110, 28'hA5A_5A5A));

    // R1 reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "a_pad_out mid", 32'(a_pad_out), 0);
    check("R1", "d_gpo mid", 32'(d_gpo), 0);
    check("R1", "c_sel mid", 32'(c_sel), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_check("R1", 8'h18, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule